// File: doc/BRIEF.md
# Paged Processor Register Interface for a Time-Slot Switch

This block sits between a simple asynchronous-style microprocessor bus and the three memories of a time-slot switch: the data memory, which holds received channel samples, and the low and high halves of the connection memory, which hold per-output-channel routing and control. The processor sees a window of only 64 byte addresses. One part of that window is a control register. The rest maps to the 32 channels of one stream. The stream is chosen by page bits held in the control register, and they form the upper part of every memory address.

The control register also selects which memory a channel access reaches. It carries two mode bits that the switch core consumes directly. The broadcast bit puts every output channel into message mode. The split bit makes reads come from the data memory while writes land in the low connection memory, at the same composed address. Each access is paced by a handshake. After chip select and strobe are both seen, the block waits a fixed number of clocks, runs one memory cycle, raises the acknowledge and holds it until the strobe goes away.

All bus inputs are taken as synchronous to the block clock. The memories are external, with a one-cycle registered read.

Top module: `paged_bus_if`

## Requirements
- R1: After reset, bus_ack is 0, bus_rdata is 0, bcast_mode and split_mode are 0, no memory strobe is active, and the control register reads back as 0x00.
- R2: bus_ack rises right after the (ACK_WAIT+2)-th clock edge that follows the first edge at which bus_sel and bus_strobe are both sampled high (default ACK_WAIT=2, so 4 edges).
- R3: While bus_sel and bus_strobe stay high, bus_ack stays high and no further memory cycle occurs. bus_ack falls at the first edge at which the strobe or the select is sampled low.
- R4: An access with bus_addr[5]=0 reaches the control register, whatever the value of bus_addr[4:0]. The control register layout is: bit 7 broadcast, bit 6 split, bit 5 reserved (always reads 0), bits 4:3 memory select (0x = data memory, 10 = low connection memory, 11 = high connection memory), bits 2:0 stream page.
- R5: An access with bus_addr[5]=1 drives mem_addr = {page[2:0], bus_addr[4:0]}. For a write, bus_wdata appears on mem_wdata.
- R6: With split off and memory select 0x, a read pulses dm_rd for one cycle and returns the data memory word on bus_rdata while bus_ack is high.
- R7: With split off, memory select 10 reads or writes through cml_rd/cml_wr, and select 11 through cmh_rd/cmh_wr. Written data can be read back.
- R8: With split off and memory select 0x, a write raises no memory strobe at all and leaves memory contents unchanged, but is still acknowledged.
- R9: With split on, every channel read uses dm_rd and every channel write uses cml_wr, whatever the memory-select bits hold.
- R10: bcast_mode follows control bit 7 and split_mode follows control bit 6 from the clock edge that completes the control write.
- R11: If the strobe or the select drops before the memory cycle is issued, no memory strobe occurs and bus_ack stays low.
- R12: Each transaction raises at most one memory strobe, for exactly one cycle. bus_rdata is 0 whenever bus_ack is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Chip select, active high |
| bus_strobe | input | 1 | Data strobe, active high |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 6 | Bus address; bit 5 = 1 selects a channel |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Data acknowledge |
| mem_addr | output | 8 | Composed memory address {page, channel} |
| mem_wdata | output | 8 | Memory write data |
| dm_rd | output | 1 | Data memory read strobe |
| dm_rdata | input | 8 | Data memory read data (one-cycle latency) |
| cml_rd | output | 1 | Low connection memory read strobe |
| cml_wr | output | 1 | Low connection memory write strobe |
| cml_rdata | input | 8 | Low connection memory read data |
| cmh_rd | output | 1 | High connection memory read strobe |
| cmh_wr | output | 1 | High connection memory write strobe |
| cmh_rdata | input | 8 | High connection memory read data |
| bcast_mode | output | 1 | Broadcast mode to the switch core |
| split_mode | output | 1 | Split mode to the switch core |

## Verification
A corrupted page or memory-select field shows up on the first later channel access. The strobe lands on the wrong memory or at the wrong address, and the bench memory models catch this as a wrong word read back or a write in the wrong array. A handshake state stuck or skipped shows within one transaction as a wrong acknowledge latency or an acknowledge that never falls. Checking strobe counts after each access, including the ignored write and the aborted one, exposes a decode that strobes when it should stay silent.

// File: rtl/paged_bus_pkg.sv
package paged_bus_pkg;

    localparam int BUS_AW  = 6;
    localparam int BUS_DW  = 8;
    localparam int PAGE_W  = 3;
    localparam int CHAN_W  = BUS_AW - 1;
    localparam int MEM_AW  = PAGE_W + CHAN_W;

    typedef enum logic [1:0] {
        MSEL_DM  = 2'b00,
        MSEL_DM2 = 2'b01,
        MSEL_CML = 2'b10,
        MSEL_CMH = 2'b11
    } msel_e;

    typedef struct packed {
        logic              bcast;
        logic              split;
        logic              rsvd;
        msel_e             msel;
        logic [PAGE_W-1:0] page;
    } ctrl_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_DM,
        TGT_CML,
        TGT_CMH
    } tgt_e;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_WAIT,
        HS_ISSUE,
        HS_CAPT,
        HS_ACK
    } hs_state_e;

    typedef struct packed {
        logic dm_rd;
        logic cml_rd;
        logic cml_wr;
        logic cmh_rd;
        logic cmh_wr;
    } strobe_t;

    // Choose the unit an access reaches from the address class and mode bits.
    function automatic tgt_e pick_target(logic is_ctrl, logic split, msel_e msel, logic rd);
        tgt_e t;
        if (is_ctrl)
            t = TGT_CTRL;
        else if (split)
            t = rd ? TGT_DM : TGT_CML;
        else begin
            case (msel)
                MSEL_CML: t = TGT_CML;
                MSEL_CMH: t = TGT_CMH;
                default:  t = rd ? TGT_DM : TGT_NONE;
            endcase
        end
        return t;
    endfunction

    function automatic logic [BUS_DW-1:0] sanitize_ctrl(logic [BUS_DW-1:0] v);
        ctrl_t c;
        c = ctrl_t'(v);
        c.rsvd = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/pbi_handshake.sv
module pbi_handshake
    import paged_bus_pkg::*;
#(
    parameter int ACK_WAIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic strobe,
    output logic issue,
    output logic capt,
    output logic ack
);
    localparam int CW = (ACK_WAIT < 2) ? 1 : $clog2(ACK_WAIT);
    localparam logic [CW-1:0] LAST = CW'(ACK_WAIT - 1);

    hs_state_e       st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            req;

    assign req = sel && strobe;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            HS_IDLE: begin
                cnt_d = '0;
                if (req) st_d = HS_WAIT;
            end
            HS_WAIT: begin
                if (!req) begin
                    st_d  = HS_IDLE;
                    cnt_d = '0;
                end else if (cnt_q == LAST) begin
                    st_d = HS_ISSUE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            HS_ISSUE: st_d = HS_CAPT;
            HS_CAPT:  st_d = HS_ACK;
            HS_ACK:   if (!req) st_d = HS_IDLE;
            default:  st_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= HS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign issue = (st_q == HS_ISSUE);
    assign capt  = (st_q == HS_CAPT);
    assign ack   = (st_q == HS_ACK);

    // R3
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && sel && strobe) |=> ack);
    // R3
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !strobe) |=> !ack);
    // R12
    issue_single_chk: assert property (@(posedge clk) disable iff (rst)
        issue |=> !issue);

endmodule

// File: rtl/pbi_ctrl_reg.sv
module pbi_ctrl_reg
    import paged_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BUS_DW-1:0] wdata,
    output ctrl_t             ctrl
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= ctrl_t'(sanitize_ctrl(wdata));
    end

    assign ctrl = ctrl_q;

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl_q.rsvd == 1'b0));

endmodule

// File: rtl/pbi_route.sv
module pbi_route
    import paged_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              is_ctrl,
    input  logic              rd,
    input  logic              split,
    input  msel_e             msel,
    output tgt_e              tgt,
    output logic              ctrl_wr,
    output strobe_t           stb
);
    always_comb begin
        tgt     = pick_target(is_ctrl, split, msel, rd);
        stb     = '0;
        ctrl_wr = 1'b0;
        if (issue) begin
            case (tgt)
                TGT_CTRL: ctrl_wr = !rd;
                TGT_DM:   stb.dm_rd = 1'b1;
                TGT_CML: begin
                    stb.cml_rd = rd;
                    stb.cml_wr = !rd;
                end
                TGT_CMH: begin
                    stb.cmh_rd = rd;
                    stb.cmh_wr = !rd;
                end
                default: ;
            endcase
        end
    end

    // R12
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb));
    // R9
    split_route_chk: assert property (@(posedge clk) disable iff (rst)
        (split && (|stb)) |-> (stb.dm_rd || stb.cml_wr));
    // R8
    no_dm_write_chk: assert property (@(posedge clk) disable iff (rst)
        ((|stb) && !rd) |-> !stb.dm_rd);

endmodule

// File: rtl/pbi_readback.sv
module pbi_readback
    import paged_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              capt,
    input  logic              ack,
    input  logic              rd,
    input  tgt_e              tgt,
    input  ctrl_t             ctrl,
    input  logic [BUS_DW-1:0] dm_rdata,
    input  logic [BUS_DW-1:0] cml_rdata,
    input  logic [BUS_DW-1:0] cmh_rdata,
    output logic [BUS_DW-1:0] rdata
);
    tgt_e              src_q;
    logic [BUS_DW-1:0] data_q;
    logic [BUS_DW-1:0] mux;

    always_comb begin
        case (src_q)
            TGT_CTRL: mux = ctrl;
            TGT_DM:   mux = dm_rdata;
            TGT_CML:  mux = cml_rdata;
            TGT_CMH:  mux = cmh_rdata;
            default:  mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= TGT_NONE;
            data_q <= '0;
        end else begin
            if (issue) src_q <= rd ? tgt : TGT_NONE;
            if (capt)  data_q <= mux;
        end
    end

    assign rdata = ack ? data_q : '0;

    // R12
    rdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && $past(ack)) |-> $stable(rdata));

endmodule

// File: rtl/paged_bus_if.sv
module paged_bus_if
    import paged_bus_pkg::*;
#(
    parameter int ACK_WAIT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_strobe,
    input  logic        bus_rd,
    input  logic [5:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        bus_ack,
    output logic [7:0]  mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        dm_rd,
    input  logic [7:0]  dm_rdata,
    output logic        cml_rd,
    output logic        cml_wr,
    input  logic [7:0]  cml_rdata,
    output logic        cmh_rd,
    output logic        cmh_wr,
    input  logic [7:0]  cmh_rdata,
    output logic        bcast_mode,
    output logic        split_mode
);
    logic    issue, capt, ack, ctrl_wr, is_ctrl;
    ctrl_t   ctrl;
    tgt_e    tgt;
    strobe_t stb;

    assign is_ctrl = !bus_addr[BUS_AW-1];

    pbi_handshake #(.ACK_WAIT(ACK_WAIT)) u_hs (
        .clk    (clk),
        .rst    (rst),
        .sel    (bus_sel),
        .strobe (bus_strobe),
        .issue  (issue),
        .capt   (capt),
        .ack    (ack)
    );

    pbi_route u_route (
        .clk     (clk),
        .rst     (rst),
        .issue   (issue),
        .is_ctrl (is_ctrl),
        .rd      (bus_rd),
        .split   (ctrl.split),
        .msel    (ctrl.msel),
        .tgt     (tgt),
        .ctrl_wr (ctrl_wr),
        .stb     (stb)
    );

    pbi_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (ctrl_wr),
        .wdata (bus_wdata),
        .ctrl  (ctrl)
    );

    pbi_readback u_rb (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .capt      (capt),
        .ack       (ack),
        .rd        (bus_rd),
        .tgt       (tgt),
        .ctrl      (ctrl),
        .dm_rdata  (dm_rdata),
        .cml_rdata (cml_rdata),
        .cmh_rdata (cmh_rdata),
        .rdata     (bus_rdata)
    );

    assign mem_addr   = {ctrl.page, bus_addr[CHAN_W-1:0]};
    assign mem_wdata  = bus_wdata;
    assign dm_rd      = stb.dm_rd;
    assign cml_rd     = stb.cml_rd;
    assign cml_wr     = stb.cml_wr;
    assign cmh_rd     = stb.cmh_rd;
    assign cmh_wr     = stb.cmh_wr;
    assign bus_ack    = ack;
    assign bcast_mode = ctrl.bcast;
    assign split_mode = ctrl.split;

    // R11
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $past(bus_sel && bus_strobe));
    // R5
    strobe_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (dm_rd || cml_rd || cml_wr || cmh_rd || cmh_wr) |-> bus_addr[BUS_AW-1]);

endmodule

// File: tb/sim_paged_bus_if.sv
`timescale 1ns/1ps
module sim_paged_bus_if;
    localparam int ACK_WAIT = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_strobe = 1'b0, bus_rd = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, mem_addr, mem_wdata;
    logic       bus_ack, dm_rd, cml_rd, cml_wr, cmh_rd, cmh_wr;
    logic       bcast_mode, split_mode;
    logic [7:0] dm_q = '0, cml_q = '0, cmh_q = '0;

    logic [7:0] dm_mem [256];
    logic [7:0] cml_mem [256];
    logic [7:0] cmh_mem [256];

    int n_chk = 0, n_err = 0;
    int n_stb = 0, n_multi = 0;
    logic [7:0] last_addr = '0;
    bit timed_out = 0;

    always #5 clk = ~clk;

    paged_bus_if #(.ACK_WAIT(ACK_WAIT)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_strobe(bus_strobe),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .dm_rd(dm_rd), .dm_rdata(dm_q),
        .cml_rd(cml_rd), .cml_wr(cml_wr), .cml_rdata(cml_q),
        .cmh_rd(cmh_rd), .cmh_wr(cmh_wr), .cmh_rdata(cmh_q),
        .bcast_mode(bcast_mode), .split_mode(split_mode)
    );

    // Memory models: registered read, write on strobe
    always @(posedge clk) begin
        if (dm_rd)  dm_q  <= dm_mem[mem_addr];
        if (cml_rd) cml_q <= cml_mem[mem_addr];
        if (cmh_rd) cmh_q <= cmh_mem[mem_addr];
        if (cml_wr) cml_mem[mem_addr] <= mem_wdata;
        if (cmh_wr) cmh_mem[mem_addr] <= mem_wdata;
        if (!rst) begin
            n_stb <= n_stb + int'(dm_rd) + int'(cml_rd) + int'(cml_wr)
                           + int'(cmh_rd) + int'(cmh_wr);
            if ((int'(dm_rd) + int'(cml_rd) + int'(cml_wr) + int'(cmh_rd) + int'(cmh_wr)) > 0)
                last_addr <= mem_addr;
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One full bus transaction; returns read data and acknowledge latency.
    task automatic xfer(input logic rd, input logic [5:0] a, input logic [7:0] wd,
                        input int extra_hold, output logic [7:0] rdv, output int lat);
        @(negedge clk);
        bus_sel = 1'b1; bus_strobe = 1'b1; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        lat = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (bus_ack) break;
            @(posedge clk);
            lat++;
        end
        rdv = bus_rdata;
        for (int i = 0; i < extra_hold; i++) begin
            @(negedge clk);
            check("R3 ack held", int'(bus_ack), 1);
            check("R3 rdata stable", int'(bus_rdata), int'(rdv));
        end
        @(negedge clk);
        bus_strobe = 1'b0; bus_sel = 1'b0;
        @(negedge clk);
        check("R3 ack released", int'(bus_ack), 0);
        check("R12 rdata zero w/o ack", int'(bus_rdata), 0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] r; int l;
        xfer(1'b0, a, d, 0, r, l);
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] r);
        int l;
        xfer(1'b1, a, 8'h00, 0, r, l);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        check("R1 ack", int'(bus_ack), 0);
        check("R1 rdata", int'(bus_rdata), 0);
        check("R1 bcast", int'(bcast_mode), 0);
        check("R1 split", int'(split_mode), 0);
        check("R1 no strobes", n_stb, 0);
        rd(6'h00, r);
        check("R1 ctrl reads 0", int'(r), 0);
    endtask

    task automatic t_ctrl();
        logic [7:0] r;
        wr(6'h00, 8'hFF);
        rd(6'h1A, r);
        check("R4 ctrl readback, rsvd 0", int'(r), 'hDF);
        check("R10 bcast on", int'(bcast_mode), 1);
        check("R10 split on", int'(split_mode), 1);
        wr(6'h13, 8'h80);
        check("R10 bcast only", int'(bcast_mode), 1);
        check("R10 split off", int'(split_mode), 0);
        wr(6'h00, 8'h00);
        check("R10 bcast off", int'(bcast_mode), 0);
        check("R4 ctrl access no strobe", n_stb, 0);
    endtask

    task automatic t_dm_read();
        logic [7:0] r; int l, s0;
        wr(6'h00, 8'h05);
        s0 = n_stb;
        xfer(1'b1, 6'h29, 8'h00, 0, r, l);
        check("R2 ack latency", l, ACK_WAIT + 2);
        check("R5 composed addr", int'(last_addr), 'hA9);
        check("R6 dm read data", int'(r), int'(dm_mem[8'hA9]));
        check("R12 one strobe", n_stb - s0, 1);
    endtask

    task automatic t_cm_rw();
        logic [7:0] r; int s0;
        wr(6'h00, 8'h12);
        wr(6'h3F, 8'h3C);
        check("R5 cml write addr", int'(last_addr), 'h5F);
        check("R7 cml written", int'(cml_mem[8'h5F]), 'h3C);
        rd(6'h3F, r);
        check("R7 cml read back", int'(r), 'h3C);
        wr(6'h00, 8'h1F);
        s0 = n_stb;
        wr(6'h20, 8'hA5);
        check("R12 one strobe cmh", n_stb - s0, 1);
        check("R7 cmh written", int'(cmh_mem[8'hE0]), 'hA5);
        check("R7 cml untouched", int'(cml_mem[8'hE0]), 0);
        rd(6'h20, r);
        check("R7 cmh read back", int'(r), 'hA5);
    endtask

    task automatic t_dm_write_ignored();
        logic [7:0] r; int l, s0;
        wr(6'h00, 8'h03);
        s0 = n_stb;
        xfer(1'b0, 6'h27, 8'h99, 0, r, l);
        check("R8 write still acked", l, ACK_WAIT + 2);
        check("R8 no strobe", n_stb - s0, 0);
        check("R8 cml untouched", int'(cml_mem[8'h67]), 0);
        check("R8 cmh untouched", int'(cmh_mem[8'h67]), 0);
        rd(6'h27, r);
        check("R8 dm unchanged", int'(r), int'(dm_mem[8'h67]));
    endtask

    task automatic t_split();
        logic [7:0] r;
        wr(6'h00, 8'h59);
        rd(6'h24, r);
        check("R9 split read from dm", int'(r), int'(dm_mem[8'h24]));
        wr(6'h24, 8'h77);
        check("R9 split write to cml", int'(cml_mem[8'h24]), 'h77);
        check("R9 cmh untouched", int'(cmh_mem[8'h24]), 0);
        rd(6'h24, r);
        check("R9 read still dm", int'(r), int'(dm_mem[8'h24]));
    endtask

    task automatic t_hold();
        logic [7:0] r; int l, s0;
        wr(6'h00, 8'h05);
        s0 = n_stb;
        xfer(1'b1, 6'h2A, 8'h00, 5, r, l);
        check("R3 held read data", int'(r), int'(dm_mem[8'hAA]));
        check("R3 no extra cycle", n_stb - s0, 1);
    endtask

    task automatic t_abort();
        int s0, seen;
        s0 = n_stb; seen = 0;
        @(negedge clk);
        bus_sel = 1'b1; bus_strobe = 1'b1; bus_rd = 1'b1; bus_addr = 6'h21;
        @(negedge clk);
        bus_strobe = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (bus_ack) seen++;
        end
        bus_sel = 1'b0;
        check("R11 no ack on abort", seen, 0);
        check("R11 no strobe on abort", n_stb - s0, 0);
    endtask

    task automatic run_all();
        t_reset();
        t_ctrl();
        t_dm_read();
        t_cm_rw();
        t_dm_write_ignored();
        t_split();
        t_hold();
        t_abort();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            dm_mem[i]  = 8'((i * 7) + 3);
            cml_mem[i] = 8'h00;
            cmh_mem[i] = 8'h00;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule